// File: doc/BRIEF.md
# Minimal 8-bit accumulator processor core

This block is a small, non-pipelined processor that runs programs from an external 256-word program store. Each 16-bit instruction word carries an opcode and an 8-bit argument. The architectural state consists of four 8-bit registers: an accumulator, an index register that doubles as a stack pointer, a status register holding an equal flag, and a program counter. Every instruction finishes in one clock, except the three that read data memory, which take two.

Data moves over a 256-byte synchronous bus. The core drives an address, write data and a write strobe. Read data is expected one clock after the address is presented, so peripherals and RAM are mapped into this address space. Two external control inputs can steer conditional jumps, which lets software poll ready lines without a bus read. The program store is read combinationally: the word at `prog_addr` is expected on `prog_word` in the same cycle.

Top module: `acc8_core`

## Requirements
- R1: The instruction word holds the opcode in bits 15:8 and the argument in bits 7:0. Codes: 00 no-op, 01 load immediate, 02 load from memory, 03 store, 04 compare, 05 jump to accumulator, 06 jump, 07 jump if nonzero, 08 jump if zero, 09 jump if equal, 0A jump if control 0, 0B jump if control 1, 0C add immediate, 0D subtract immediate, 0E push immediate, 0F push accumulator, 10 pop, 11 set stack pointer, 12 set index, 13 increment index, 14 load via index, 15 exchange, 16 trap. Any other code behaves as a no-op.
- R2: A synchronous reset clears the program counter, status, accumulator and index, so `prog_addr` reads 0 after reset. `bus_we` stays low while reset is high.
- R3: Load immediate sets the accumulator to the argument. Store drives the accumulator on `bus_wdata` and the argument on `bus_addr`, with `bus_we` high for exactly that one cycle.
- R4: Load from memory presents the argument address in its first cycle, holds the program counter, takes `bus_rdata` into the accumulator in its second cycle, and only then advances.
- R5: Add immediate and subtract immediate update the accumulator modulo 256.
- R6: Compare sets status bit 0 when the accumulator equals the argument and clears it otherwise. Jump-if-equal is taken only when that bit is set.
- R7: Jump always loads the argument into the program counter. Jump-if-nonzero and jump-if-zero test the accumulator. Jump-to-accumulator loads the program counter from the accumulator.
- R8: Jump-if-control-0 and jump-if-control-1 are taken when `ctrl_in[0]` or `ctrl_in[1]` respectively is high.
- R9: Push immediate and push accumulator write their value to the address held in the index register, then increment the index.
- R10: Pop decrements the index first, reads the byte at the new index over two cycles, and places it in the accumulator.
- R11: Set stack pointer and set index both load the index with the argument. Increment index adds one. Load via index reads the byte at the index into the accumulator in two cycles. Exchange swaps the accumulator and the index.
- R12: Trap clears the program counter, status, accumulator and index in one cycle.
- R13: Every instruction other than the taken jumps, trap and the memory reads completes in one cycle and advances the program counter by exactly one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| prog_addr | output | 8 | Program store address (the program counter) |
| prog_word | input | 16 | Instruction word at `prog_addr`, same cycle |
| bus_addr | output | 8 | Data bus address |
| bus_wdata | output | 8 | Data bus write value |
| bus_we | output | 1 | Data bus write strobe |
| bus_rdata | input | 8 | Data bus read value, valid one cycle after the address |
| ctrl_in | input | 2 | External branch condition lines |

## Verification
The assertions take for granted that `bus_rdata` is a registered read of the address driven in the previous cycle. They also assume that `prog_word` stays steady while a two-cycle read is in progress, because the instruction is not latched. The bench models the program store as a combinational array and the data space as a clocked RAM. It changes `ctrl_in` and the program store only at the falling edge. It rewrites the store only once the core has been observed at a known address.

// File: rtl/acc8_pkg.sv
package acc8_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned OPC_W  = 8;
    localparam int unsigned WORD_W = OPC_W + DATA_W;
    localparam int unsigned CTRL_N = 2;

    typedef enum logic [OPC_W-1:0] {
        OP_NOP   = 8'h00,
        OP_LDI   = 8'h01,
        OP_LDM   = 8'h02,
        OP_STM   = 8'h03,
        OP_CMPI  = 8'h04,
        OP_JREG  = 8'h05,
        OP_JMP   = 8'h06,
        OP_JNZ   = 8'h07,
        OP_JZ    = 8'h08,
        OP_JEQ   = 8'h09,
        OP_JC0   = 8'h0A,
        OP_JC1   = 8'h0B,
        OP_ADDI  = 8'h0C,
        OP_SUBI  = 8'h0D,
        OP_PUSHI = 8'h0E,
        OP_PUSHR = 8'h0F,
        OP_POP   = 8'h10,
        OP_SETSP = 8'h11,
        OP_SETIX = 8'h12,
        OP_INCIX = 8'h13,
        OP_LDIX  = 8'h14,
        OP_XCHG  = 8'h15,
        OP_TRAP  = 8'h16
    } op_e;

    typedef struct packed {
        op_e  op;
        logic two_cycle;
        logic is_jump;
        logic is_push;
    } dec_t;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] sr;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] idx;
        logic              rd_phase;
    } core_state_t;

    localparam int unsigned EQ_BIT = 0;

endpackage

// File: rtl/acc8_decode.sv
module acc8_decode
    import acc8_pkg::*;
(
    input  logic [OPC_W-1:0] opc_raw,
    output dec_t             dec
);
    op_e op_v;

    always_comb begin
        if (opc_raw <= OPC_W'(OP_TRAP)) begin
            op_v = op_e'(opc_raw);
        end else begin
            op_v = OP_NOP;
        end
        dec.op        = op_v;
        dec.two_cycle = (op_v == OP_LDM) || (op_v == OP_POP) || (op_v == OP_LDIX);
        dec.is_jump   = (op_v == OP_JREG) || (op_v == OP_JMP) || (op_v == OP_JNZ) ||
                        (op_v == OP_JZ)   || (op_v == OP_JEQ) || (op_v == OP_JC0) ||
                        (op_v == OP_JC1);
        dec.is_push   = (op_v == OP_PUSHI) || (op_v == OP_PUSHR);
    end

endmodule

// File: rtl/acc8_alu.sv
module acc8_alu #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y
);
    logic [W-1:0] b_eff;

    always_comb begin
        b_eff = sub ? ~b : b;
        y     = a + b_eff + W'(sub);
    end

endmodule

// File: rtl/acc8_core.sv
module acc8_core
    import acc8_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    output logic [ADDR_W-1:0]     prog_addr,
    input  logic [WORD_W-1:0]     prog_word,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic [DATA_W-1:0]     bus_wdata,
    output logic                  bus_we,
    input  logic [DATA_W-1:0]     bus_rdata,
    input  logic [CTRL_N-1:0]     ctrl_in
);
    core_state_t st_q, st_d;
    dec_t        dec;
    logic [DATA_W-1:0] arg;
    logic [DATA_W-1:0] alu_y;
    logic [ADDR_W-1:0] pc_next;
    logic              advance;
    logic              we_int;

    assign arg = prog_word[DATA_W-1:0];

    acc8_decode u_dec (
        .opc_raw (prog_word[WORD_W-1:DATA_W]),
        .dec     (dec)
    );

    acc8_alu #(.W(DATA_W)) u_alu (
        .a   (st_q.acc),
        .b   (arg),
        .sub (dec.op == OP_SUBI),
        .y   (alu_y)
    );

    always_comb begin
        st_d      = st_q;
        pc_next   = st_q.pc + ADDR_W'(1);
        advance   = 1'b1;
        bus_addr  = arg;
        bus_wdata = st_q.acc;
        we_int    = 1'b0;

        case (dec.op)
            OP_LDI:  st_d.acc = arg;
            OP_STM:  we_int = 1'b1;
            OP_CMPI: st_d.sr[EQ_BIT] = (st_q.acc == arg);
            OP_JREG: pc_next = st_q.acc;
            OP_JMP:  pc_next = arg;
            OP_JNZ:  if (st_q.acc != '0) pc_next = arg;
            OP_JZ:   if (st_q.acc == '0) pc_next = arg;
            OP_JEQ:  if (st_q.sr[EQ_BIT]) pc_next = arg;
            OP_JC0:  if (ctrl_in[0]) pc_next = arg;
            OP_JC1:  if (ctrl_in[1]) pc_next = arg;
            OP_ADDI, OP_SUBI: st_d.acc = alu_y;
            OP_PUSHI, OP_PUSHR: begin
                bus_addr  = st_q.idx;
                bus_wdata = (dec.op == OP_PUSHI) ? arg : st_q.acc;
                we_int    = 1'b1;
                st_d.idx  = st_q.idx + DATA_W'(1);
            end
            OP_SETSP, OP_SETIX: st_d.idx = arg;
            OP_INCIX: st_d.idx = st_q.idx + DATA_W'(1);
            OP_XCHG: begin
                st_d.acc = st_q.idx;
                st_d.idx = st_q.acc;
            end
            OP_LDM, OP_LDIX, OP_POP: begin
                if (dec.op != OP_LDM) bus_addr = st_q.idx;
                if (!st_q.rd_phase) begin
                    advance       = 1'b0;
                    st_d.rd_phase = 1'b1;
                    if (dec.op == OP_POP) begin
                        bus_addr = st_q.idx - DATA_W'(1);
                        st_d.idx = st_q.idx - DATA_W'(1);
                    end
                end else begin
                    st_d.acc      = bus_rdata;
                    st_d.rd_phase = 1'b0;
                end
            end
            OP_TRAP: begin
                st_d    = '0;
                pc_next = '0;
            end
            default: ;
        endcase

        if (advance) st_d.pc = pc_next;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prog_addr = st_q.pc;
    assign bus_we    = we_int & ~rst;

    AST_NO_WRITE_IN_RESET: assert property (@(posedge clk) rst |-> !bus_we) // R2
        else $error("write strobe during reset");

    AST_READ_HOLDS_PC: assert property (@(posedge clk) disable iff (rst)
        (dec.two_cycle && !st_q.rd_phase) |=> (prog_addr == $past(prog_addr) && st_q.rd_phase)) // R4
        else $error("pc moved in first read cycle");

    AST_READ_ENDS: assert property (@(posedge clk) disable iff (rst)
        st_q.rd_phase |=> !st_q.rd_phase) // R4
        else $error("read lasted more than two cycles");

    AST_PUSH_INC: assert property (@(posedge clk) disable iff (rst)
        (dec.is_push && bus_we) |=> (st_q.idx == $past(bus_addr) + DATA_W'(1))) // R9
        else $error("index not incremented after push");

    AST_POP_DEC: assert property (@(posedge clk) disable iff (rst)
        (dec.op == OP_POP && !st_q.rd_phase) |=> (st_q.idx == $past(st_q.idx) - DATA_W'(1))) // R10
        else $error("index not decremented by pop");

    AST_TRAP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (dec.op == OP_TRAP) |=> (prog_addr == '0 && st_q.acc == '0 && st_q.idx == '0 && st_q.sr == '0)) // R12
        else $error("trap left state behind");

    AST_SEQ_PC: assert property (@(posedge clk) disable iff (rst)
        (!dec.is_jump && !dec.two_cycle && dec.op != OP_TRAP)
            |=> (prog_addr == $past(prog_addr) + ADDR_W'(1))) // R13
        else $error("pc did not step by one");

endmodule

// File: tb/tb_acc8_core.sv
module tb_acc8_core;
    localparam int CLK_PERIOD = 10;

    localparam logic [7:0] C_NOP = 8'h00, C_LDI = 8'h01, C_LDM = 8'h02, C_STM = 8'h03,
        C_CMPI = 8'h04, C_JREG = 8'h05, C_JMP = 8'h06, C_JNZ = 8'h07, C_JZ = 8'h08,
        C_JEQ = 8'h09, C_JC0 = 8'h0A, C_JC1 = 8'h0B, C_ADDI = 8'h0C, C_SUBI = 8'h0D,
        C_PUSHI = 8'h0E, C_PUSHR = 8'h0F, C_POP = 8'h10, C_SETSP = 8'h11,
        C_SETIX = 8'h12, C_INCIX = 8'h13, C_LDIX = 8'h14, C_XCHG = 8'h15, C_TRAP = 8'h16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  prog_addr;
    logic [15:0] prog_word;
    logic [7:0]  bus_addr, bus_wdata, bus_rdata;
    logic        bus_we;
    logic [1:0]  ctrl_in = 2'b00;

    logic [15:0] rom [256];
    logic [7:0]  dmem [256];
    logic        pre_we = 1'b0;
    logic [7:0]  pre_addr = '0, pre_data = '0;
    int          wr_cnt = 0;
    int          n_checks = 0;
    int          n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign prog_word = rom[prog_addr];

    always @(posedge clk) begin
        if (pre_we) begin
            dmem[pre_addr] <= pre_data;
        end else if (bus_we) begin
            dmem[bus_addr] <= bus_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        bus_rdata <= dmem[bus_addr];
    end

    acc8_core dut (
        .clk(clk), .rst(rst), .prog_addr(prog_addr), .prog_word(prog_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_rdata(bus_rdata), .ctrl_in(ctrl_in)
    );

    function automatic logic [15:0] ins(logic [7:0] opc, logic [7:0] a);
        return {opc, a};
    endfunction

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_rom();
        for (int i = 0; i < 256; i++) rom[i] = ins(C_JMP, 8'hFF);
    endtask

    task automatic preset(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        pre_we = 1'b1; pre_addr = a; pre_data = d;
        @(posedge clk);
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_until(logic [7:0] halt, output int cycles);
        cycles = 0;
        while (prog_addr != halt && cycles < 300) begin
            @(posedge clk);
            @(negedge clk);
            cycles++;
        end
    endtask

    task automatic t_reset();
        clear_rom();
        rom[0] = ins(C_LDI, 8'h01);
        rom[1] = ins(C_JMP, 8'h01);
        do_reset();
        chk("R2 pc after reset", prog_addr, 0);
        chk("R2 no write after reset", bus_we, 0);
        @(posedge clk); @(negedge clk);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R2 pc cleared by reset", prog_addr, 0);
        chk("R2 strobe low in reset", bus_we, 0);
        rst = 1'b0;
    endtask

    task automatic t_alu();
        int cyc, w0;
        clear_rom();
        rom[0] = ins(C_LDI, 8'h5A);
        rom[1] = ins(C_STM, 8'h10);
        rom[2] = ins(C_LDI, 8'hFF);
        rom[3] = ins(C_ADDI, 8'h02);
        rom[4] = ins(C_STM, 8'h11);
        rom[5] = ins(C_SUBI, 8'h03);
        rom[6] = ins(C_STM, 8'h12);
        rom[7] = ins(8'hFF, 8'h12);
        rom[8] = ins(C_JMP, 8'h08);
        do_reset();
        w0 = wr_cnt;
        run_until(8'h08, cyc);
        chk("R3 store of loaded value", dmem[8'h10], 8'h5A);
        chk("R5 add wraps", dmem[8'h11], 8'h01);
        chk("R5 subtract wraps", dmem[8'h12], 8'hFE);
        chk("R13 one cycle per op", cyc, 8);
        chk("R1 unknown code writes nothing", wr_cnt - w0, 3);
    endtask

    task automatic t_read();
        int cyc;
        clear_rom();
        rom[0] = ins(C_LDM, 8'h20);
        rom[1] = ins(C_STM, 8'h30);
        rom[2] = ins(C_LDM, 8'h21);
        rom[3] = ins(C_STM, 8'h31);
        rom[4] = ins(C_JMP, 8'h04);
        preset(8'h20, 8'hC3);
        preset(8'h21, 8'h3C);
        do_reset();
        chk("R4 read address shown", bus_addr, 8'h20);
        @(posedge clk); @(negedge clk);
        chk("R4 pc held in first read cycle", prog_addr, 0);
        @(posedge clk); @(negedge clk);
        chk("R4 pc advances after read", prog_addr, 1);
        run_until(8'h04, cyc);
        chk("R4 remaining cycles", cyc, 4);
        chk("R4 read data 0", dmem[8'h30], 8'hC3);
        chk("R4 read data 1", dmem[8'h31], 8'h3C);
    endtask

    task automatic t_branch();
        int cyc;
        clear_rom();
        rom[8'h00] = ins(C_LDI, 8'h00);
        rom[8'h01] = ins(C_JNZ, 8'h1F);
        rom[8'h02] = ins(C_JZ, 8'h04);
        rom[8'h03] = ins(C_STM, 8'h40);
        rom[8'h04] = ins(C_CMPI, 8'h01);
        rom[8'h05] = ins(C_JEQ, 8'h1F);
        rom[8'h06] = ins(C_CMPI, 8'h00);
        rom[8'h07] = ins(C_JEQ, 8'h09);
        rom[8'h08] = ins(C_JMP, 8'h1F);
        rom[8'h09] = ins(C_JC1, 8'h1F);
        rom[8'h0A] = ins(C_JC0, 8'h0C);
        rom[8'h0B] = ins(C_JMP, 8'h1F);
        rom[8'h0C] = ins(C_LDI, 8'h0F);
        rom[8'h0D] = ins(C_JREG, 8'h00);
        rom[8'h0E] = ins(C_JMP, 8'h1F);
        rom[8'h0F] = ins(C_LDI, 8'h77);
        rom[8'h10] = ins(C_JNZ, 8'h12);
        rom[8'h11] = ins(C_JMP, 8'h1F);
        rom[8'h12] = ins(C_STM, 8'h41);
        rom[8'h13] = ins(C_JMP, 8'h13);
        rom[8'h1F] = ins(C_JMP, 8'h1F);
        preset(8'h40, 8'hAA);
        ctrl_in = 2'b01;
        do_reset();
        run_until(8'h13, cyc);
        chk("R7 taken jump path length", cyc, 14);
        chk("R7 skipped store untouched", dmem[8'h40], 8'hAA);
        chk("R8 R6 path reached end", dmem[8'h41], 8'h77);
        ctrl_in = 2'b00;
    endtask

    task automatic t_stack();
        int cyc;
        clear_rom();
        rom[8'h00] = ins(C_SETIX, 8'h50);
        rom[8'h01] = ins(C_PUSHI, 8'h11);
        rom[8'h02] = ins(C_LDI, 8'h22);
        rom[8'h03] = ins(C_PUSHR, 8'h00);
        rom[8'h04] = ins(C_POP, 8'h00);
        rom[8'h05] = ins(C_STM, 8'h60);
        rom[8'h06] = ins(C_POP, 8'h00);
        rom[8'h07] = ins(C_STM, 8'h61);
        rom[8'h08] = ins(C_XCHG, 8'h00);
        rom[8'h09] = ins(C_STM, 8'h62);
        rom[8'h0A] = ins(C_XCHG, 8'h00);
        rom[8'h0B] = ins(C_SETSP, 8'h51);
        rom[8'h0C] = ins(C_LDIX, 8'h00);
        rom[8'h0D] = ins(C_INCIX, 8'h00);
        rom[8'h0E] = ins(C_XCHG, 8'h00);
        rom[8'h0F] = ins(C_STM, 8'h63);
        rom[8'h10] = ins(C_JMP, 8'h10);
        do_reset();
        run_until(8'h10, cyc);
        chk("R9 push immediate", dmem[8'h50], 8'h11);
        chk("R9 push accumulator", dmem[8'h51], 8'h22);
        chk("R10 first pop", dmem[8'h60], 8'h22);
        chk("R10 second pop", dmem[8'h61], 8'h11);
        chk("R11 exchange gives index", dmem[8'h62], 8'h50);
        chk("R11 set, load via index, increment", dmem[8'h63], 8'h52);
        chk("R11 R10 cycle count", cyc, 19);
    endtask

    task automatic t_trap();
        int cyc;
        clear_rom();
        rom[0] = ins(C_LDI, 8'h77);
        rom[1] = ins(C_SETIX, 8'h55);
        rom[2] = ins(C_CMPI, 8'h77);
        rom[3] = ins(C_TRAP, 8'h00);
        preset(8'h70, 8'hAA);
        preset(8'h71, 8'hAA);
        do_reset();
        repeat (4) begin
            @(posedge clk);
            @(negedge clk);
        end
        chk("R12 pc cleared by trap", prog_addr, 0);
        clear_rom();
        rom[0] = ins(C_JEQ, 8'h1F);
        rom[1] = ins(C_STM, 8'h70);
        rom[2] = ins(C_XCHG, 8'h00);
        rom[3] = ins(C_STM, 8'h71);
        rom[4] = ins(C_JMP, 8'h04);
        rom[8'h1F] = ins(C_JMP, 8'h1F);
        run_until(8'h04, cyc);
        chk("R12 equal flag cleared", cyc, 4);
        chk("R12 accumulator cleared", dmem[8'h70], 8'h00);
        chk("R12 index cleared", dmem[8'h71], 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) dmem[i] = 8'h00;
        clear_rom();
        t_reset();
        t_alu();
        t_read();
        t_branch();
        t_stack();
        t_trap();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule